// File: doc/BRIEF.md
# Programmable Audio-Interface Timing Aligner

This block sits between the serial audio pins and the transmitter and receiver cores. It re-times the bit clock, word select and serial data against a fast reference clock. Every inbound signal goes through a two-flop synchronizer that mixes clock edges, followed by a whole-cycle delay line. The result is a latency set in half-cycle steps, from 1.5 to 4.5 reference cycles. Every outbound signal gets a programmable delay of 0 to 3 whole reference cycles. A data-valid flag travels through an inbound-style path of its own.

A single 32-bit control word sets every delay, the synchronizer edge order for each direction, and an optional inversion of the inbound transmit bit clock. The word is written through a one-cycle write strobe and can be read back. Each path is configured on its own, so board-level skew can be trimmed signal by signal.

Top module: `audioTimingAligner`

## Requirements
- R1: While reset is asserted, every synchronized inbound output is low and the control readback is zero. The control word therefore starts at zero: inbound latency 1.5 cycles, no outbound delay, rising-edge-first order and no inversion.
- R2: When `cfgWrEn` is high at a rising edge, bits 24:0 of `cfgWrData` are stored. From the next cycle the readback returns them, and bits 31:25 always read as zero.
- R3: An inbound path whose 2-bit code is c delivers, after c+1.5 reference cycles, the value its first synchronizer flop captured. The code fields sit at bits 1:0 (transmit bit clock), 3:2 (transmit word select), 5:4 (receive bit clock), 7:6 (receive word select) and 9:8 (receive data).
- R4: Bit 20 sets the edge order for the transmit inbound paths and bit 21 sets it for the receive inbound paths. A value of 0 makes the first flop sample on the rising edge and the second on the falling edge. A value of 1 reverses this, so the first flop samples on the falling edge.
- R5: An outbound path with code c drives its pad with the core value delayed by exactly c rising edges, and code 0 passes the value through combinationally. The fields sit at bits 11:10 (transmit bit clock), 13:12 (transmit word select), 15:14 (transmit data), 17:16 (receive word select) and 19:18 (receive bit clock).
- R6: The data-valid flag follows the inbound timing rule with its code in bits 23:22 and uses the receive edge order from bit 21.
- R7: Bit 24 inverts the inbound transmit bit clock ahead of its synchronizer, so the inverted signal has the same latency as the plain one.
- R8: Each field acts only on its own path. A different code or order on one path leaves the timing of every other path unchanged.
- R9: After any control write, every path returns to its specified timing within 8 reference cycles, with no stuck or stalled output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Control word write strobe |
| cfgWrData | input | 32 | Control word write value |
| cfgRdData | output | 32 | Control word readback |
| txBckPadIn | input | 1 | Bit clock from pad toward transmitter |
| txWsPadIn | input | 1 | Word select from pad toward transmitter |
| rxBckPadIn | input | 1 | Bit clock from pad toward receiver |
| rxWsPadIn | input | 1 | Word select from pad toward receiver |
| rxSdPadIn | input | 1 | Serial data from pad toward receiver |
| validPadIn | input | 1 | Data-valid flag before re-timing |
| txBckSync | output | 1 | Re-timed transmit bit clock |
| txWsSync | output | 1 | Re-timed transmit word select |
| rxBckSync | output | 1 | Re-timed receive bit clock |
| rxWsSync | output | 1 | Re-timed receive word select |
| rxSdSync | output | 1 | Re-timed receive data |
| validSync | output | 1 | Re-timed data-valid flag |
| txBckCoreOut | input | 1 | Transmitter bit clock toward pad |
| txWsCoreOut | input | 1 | Transmitter word select toward pad |
| txSdCoreOut | input | 1 | Transmitter data toward pad |
| rxWsCoreOut | input | 1 | Receiver word select toward pad |
| rxBckCoreOut | input | 1 | Receiver bit clock toward pad |
| txBckPadOut | output | 1 | Delayed transmit bit clock at pad |
| txWsPadOut | output | 1 | Delayed transmit word select at pad |
| txSdPadOut | output | 1 | Delayed transmit data at pad |
| rxWsPadOut | output | 1 | Delayed receive word select at pad |
| rxBckPadOut | output | 1 | Delayed receive bit clock at pad |

## Verification
The bench changes inputs on every half period as well as in slow runs, so a path that is off by half a cycle or picks the wrong tap shows up as a mismatch against a model that counts latency in clock edges. Every code is tried under all four combinations of edge order. A swapped edge order moves the output by half a cycle, and a design that confuses the transmit order bit with the receive order bit fails on the paths of the other direction. The fields are written with different codes on different paths, so a field decoded from the wrong bit position breaks a neighbouring path. The bench also checks the combinational code-0 outbound case and the inversion, and it requires correct timing to return after each rewrite of the control word, which catches a delay line that sticks.

// File: rtl/alignPkg.sv
package alignPkg;
  localparam int CODE_W   = 2;
  localparam int NUM_IN   = 6;
  localparam int NUM_OUT  = 5;
  localparam int CFG_W    = 32;
  localparam int CFG_USED = 25;

  // inbound path indices
  localparam int IN_TX_BCK = 0;
  localparam int IN_TX_WS  = 1;
  localparam int IN_RX_BCK = 2;
  localparam int IN_RX_WS  = 3;
  localparam int IN_RX_SD  = 4;
  localparam int IN_VALID  = 5;

  // outbound path indices
  localparam int OUT_TX_BCK = 0;
  localparam int OUT_TX_WS  = 1;
  localparam int OUT_TX_SD  = 2;
  localparam int OUT_RX_WS  = 3;
  localparam int OUT_RX_BCK = 4;

  localparam int TX_ORDER_BIT = 20;
  localparam int RX_ORDER_BIT = 21;
  localparam int VALID_LSB    = 22;
  localparam int INVERT_BIT   = 24;
  localparam int OUT_BASE_LSB = 10;

  function automatic int inFieldLsb(input int idx);
    return (idx == IN_VALID) ? VALID_LSB : CODE_W * idx;
  endfunction

  function automatic int outFieldLsb(input int idx);
    return OUT_BASE_LSB + CODE_W * idx;
  endfunction

  function automatic int orderBit(input int idx);
    return (idx == IN_TX_BCK || idx == IN_TX_WS) ? TX_ORDER_BIT : RX_ORDER_BIT;
  endfunction

  typedef struct packed {
    logic [NUM_IN-1:0][CODE_W-1:0]  inCode;
    logic [NUM_IN-1:0]              inFallFirst;
    logic [NUM_OUT-1:0][CODE_W-1:0] outCode;
    logic                           txBckInvert;
  } alignCtrl_t;
endpackage

// File: rtl/inSyncPath.sv
module inSyncPath #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              padIn,
  input  logic              fallFirst,
  input  logic [CODE_W-1:0] code,
  output logic              coreOut
);
  localparam int DEPTH = 2 ** CODE_W;

  logic riseA, fallA, riseB, fallB;
  logic [DEPTH-1:0] posChain, negChain;

  // first stage: both edges capture the pad
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseA    <= 1'b0;
      riseB    <= 1'b0;
      posChain <= '0;
    end else begin
      riseA    <= padIn;
      riseB    <= fallA;
      posChain <= {posChain[DEPTH-2:0], riseB};
    end
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      fallA    <= 1'b0;
      fallB    <= 1'b0;
      negChain <= '0;
    end else begin
      fallA    <= padIn;
      fallB    <= riseA;
      negChain <= {negChain[DEPTH-2:0], fallB};
    end
  end

  // rising-first ends on a falling edge, falling-first on a rising edge
  always_comb begin
    coreOut = fallFirst ? posChain[code] : negChain[code];
  end
endmodule

// File: rtl/outDelayPath.sv
module outDelayPath #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreIn,
  input  logic [CODE_W-1:0] code,
  output logic              padOut
);
  localparam int STAGES = 2 ** CODE_W - 1;

  logic [STAGES-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= '0;
    else       stage <= {stage[STAGES-2:0], coreIn};
  end

  always_comb begin
    if (code == '0) padOut = coreIn;
    else            padOut = stage[code - CODE_W'(1)];
  end
endmodule

// File: rtl/alignCtrl.sv
module alignCtrl
  import alignPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  output alignCtrl_t       ctrl
);
  localparam logic [CFG_W-1:0] USED_MASK = CFG_W'((64'd1 << CFG_USED) - 64'd1);

  logic [CFG_W-1:0] cfgReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cfgReg <= '0;
    else if (cfgWrEn) cfgReg <= cfgWrData & USED_MASK;
  end

  assign cfgRdData = cfgReg;

  always_comb begin
    ctrl = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      ctrl.inCode[i]      = cfgReg[inFieldLsb(i) +: CODE_W];
      ctrl.inFallFirst[i] = cfgReg[orderBit(i)];
    end
    for (int k = 0; k < NUM_OUT; k++) begin
      ctrl.outCode[k] = cfgReg[outFieldLsb(k) +: CODE_W];
    end
    ctrl.txBckInvert = cfgReg[INVERT_BIT];
  end
endmodule

// File: rtl/alignDatapath.sv
module alignDatapath
  import alignPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  alignCtrl_t         ctrl,
  input  logic [NUM_IN-1:0]  inPad,
  output logic [NUM_IN-1:0]  inCore,
  input  logic [NUM_OUT-1:0] outCore,
  output logic [NUM_OUT-1:0] outPad
);
  logic [NUM_IN-1:0] invMask, preSync;

  // inversion ahead of the synchronizer keeps latency identical
  assign invMask = NUM_IN'(ctrl.txBckInvert) << IN_TX_BCK;
  assign preSync = inPad ^ invMask;

  for (genvar i = 0; i < NUM_IN; i++) begin : gIn
    inSyncPath #(.CODE_W(CODE_W)) uPath (
      .clk      (clk),
      .rstN     (rstN),
      .padIn    (preSync[i]),
      .fallFirst(ctrl.inFallFirst[i]),
      .code     (ctrl.inCode[i]),
      .coreOut  (inCore[i])
    );
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : gOut
    outDelayPath #(.CODE_W(CODE_W)) uPath (
      .clk   (clk),
      .rstN  (rstN),
      .coreIn(outCore[k]),
      .code  (ctrl.outCode[k]),
      .padOut(outPad[k])
    );
  end
endmodule

// File: rtl/audioTimingAligner.sv
module audioTimingAligner
  import alignPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  input  logic        txBckPadIn,
  input  logic        txWsPadIn,
  input  logic        rxBckPadIn,
  input  logic        rxWsPadIn,
  input  logic        rxSdPadIn,
  input  logic        validPadIn,
  output logic        txBckSync,
  output logic        txWsSync,
  output logic        rxBckSync,
  output logic        rxWsSync,
  output logic        rxSdSync,
  output logic        validSync,
  input  logic        txBckCoreOut,
  input  logic        txWsCoreOut,
  input  logic        txSdCoreOut,
  input  logic        rxWsCoreOut,
  input  logic        rxBckCoreOut,
  output logic        txBckPadOut,
  output logic        txWsPadOut,
  output logic        txSdPadOut,
  output logic        rxWsPadOut,
  output logic        rxBckPadOut
);
  alignCtrl_t         ctrl;
  logic [NUM_IN-1:0]  inPad, inCore;
  logic [NUM_OUT-1:0] outCore, outPad;

  assign inPad = {validPadIn, rxSdPadIn, rxWsPadIn, rxBckPadIn, txWsPadIn, txBckPadIn};
  assign {validSync, rxSdSync, rxWsSync, rxBckSync, txWsSync, txBckSync} = inCore;
  assign outCore = {rxBckCoreOut, rxWsCoreOut, txSdCoreOut, txWsCoreOut, txBckCoreOut};
  assign {rxBckPadOut, rxWsPadOut, txSdPadOut, txWsPadOut, txBckPadOut} = outPad;

  alignCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData),
    .ctrl     (ctrl)
  );

  alignDatapath uData (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .inPad  (inPad),
    .inCore (inCore),
    .outCore(outCore),
    .outPad (outPad)
  );
endmodule

// File: rtl/alignChecker.sv
module alignChecker (
  input logic        clk,
  input logic        rstN,
  input logic        cfgWrEn,
  input logic [31:0] cfgWrData,
  input logic [31:0] cfgRdData,
  input logic        txSdCoreOut,
  input logic        txSdPadOut,
  input logic        rxSdPadIn,
  input logic        rxSdSync
);
  logic [2:0] sinceRst;
  logic       armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end
  assign armed = (sinceRst >= 3'd4);

  // R2: written value appears on the readback with reserved bits cleared
  assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(cfgWrEn)) |-> (cfgRdData == ($past(cfgWrData) & 32'h01FF_FFFF)));

  // R5: transmit data outbound delay at codes 0, 1 and 3
  assert_out_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && cfgRdData[15:14] == 2'd0) |-> (txSdPadOut == txSdCoreOut));
  assert_out_one_R5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && cfgRdData[15:14] == 2'd1) |-> (txSdPadOut == $past(txSdCoreOut)));
  assert_out_three_R5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && cfgRdData[15:14] == 2'd3) |-> (txSdPadOut == $past(txSdCoreOut, 3)));

  // R3 R4: receive data with code 0 lags its first sampling edge by 1.5 cycles
  assert_rise_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !cfgRdData[21] && cfgRdData[9:8] == 2'd0) |-> (rxSdSync == $past(rxSdPadIn, 2)));
  assert_fall_first_R4: assert property (@(negedge clk) disable iff (!rstN)
    (armed && cfgRdData[21] && cfgRdData[9:8] == 2'd0) |-> (rxSdSync == $past(rxSdPadIn, 2)));
endmodule

bind audioTimingAligner alignChecker i_alignChecker (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWrEn    (cfgWrEn),
  .cfgWrData  (cfgWrData),
  .cfgRdData  (cfgRdData),
  .txSdCoreOut(txSdCoreOut),
  .txSdPadOut (txSdPadOut),
  .rxSdPadIn  (rxSdPadIn),
  .rxSdSync   (rxSdSync)
);

// File: tb/test_audioTimingAligner.sv
module test_audioTimingAligner;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic [5:0] padIn = '0;   // txBck, txWs, rxBck, rxWs, rxSd, valid (bit 0 first)
  logic [4:0] coreOut = '0; // txBck, txWs, txSd, rxWs, rxBck (bit 0 first)
  logic [5:0] syncV;
  logic [4:0] padOutV;

  int errors = 0;
  int checks = 0;
  bit checkOn = 0;
  bit recOn = 0;
  bit done = 0;
  logic [31:0] cfgShadow = '0;

  bit         riseQ[$];
  logic [5:0] inQ[$];
  logic [4:0] outQ[$];

  audioTimingAligner i_audioTimingAligner (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .txBckPadIn(padIn[0]), .txWsPadIn(padIn[1]), .rxBckPadIn(padIn[2]),
    .rxWsPadIn(padIn[3]), .rxSdPadIn(padIn[4]), .validPadIn(padIn[5]),
    .txBckSync(syncV[0]), .txWsSync(syncV[1]), .rxBckSync(syncV[2]),
    .rxWsSync(syncV[3]), .rxSdSync(syncV[4]), .validSync(syncV[5]),
    .txBckCoreOut(coreOut[0]), .txWsCoreOut(coreOut[1]), .txSdCoreOut(coreOut[2]),
    .rxWsCoreOut(coreOut[3]), .rxBckCoreOut(coreOut[4]),
    .txBckPadOut(padOutV[0]), .txWsPadOut(padOutV[1]), .txSdPadOut(padOutV[2]),
    .rxWsPadOut(padOutV[3]), .rxBckPadOut(padOutV[4])
  );

  always #(HALF) clk = ~clk;

  function automatic int inLsb(input int j);
    return (j == 5) ? 22 : 2 * j;
  endfunction

  function automatic int ordBit(input int j);
    return (j < 2) ? 20 : 21;
  endfunction

  // reference: latency counted in clock edges from the first-flop sampling edge
  function automatic logic expIn(input int j);
    int code = int'((cfgShadow >> inLsb(j)) & 32'd3);
    bit wantRise = !cfgShadow[ordBit(j)];
    int last = riseQ.size() - 1;
    logic inv = (j == 0) ? cfgShadow[24] : 1'b0;
    for (int e = last - (2 * code + 3); e >= 0; e--)
      if (riseQ[e] == wantRise) return inQ[e][j] ^ inv;
    return 1'b0;
  endfunction

  function automatic logic expOut(input int k);
    int code = int'((cfgShadow >> (10 + 2 * k)) & 32'd3);
    int last = riseQ.size() - 1;
    if (code == 0) return coreOut[k];
    for (int e = last - 2 * (code - 1); e >= 0; e--)
      if (riseQ[e]) return outQ[e][k];
    return 1'b0;
  endfunction

  function automatic string inTag(input int j);
    if (j == 0) return "R7 R3 R4 R8 R9";
    if (j == 5) return "R6 R4 R8 R9";
    return "R3 R4 R8 R9";
  endfunction

  task automatic checkEq(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // history at every edge, taken before any input moves
  always @(clk) begin
    if (recOn) begin
      riseQ.push_back(clk);
      inQ.push_back(padIn);
      outQ.push_back(coreOut);
    end
  end

  // compare against the model a few time units after every edge
  always @(clk) begin
    #3;
    if (checkOn) begin
      for (int j = 0; j < 6; j++)
        checkEq(inTag(j), $sformatf("inbound path %0d", j), 32'(syncV[j]), 32'(expIn(j)));
      for (int k = 0; k < 5; k++)
        checkEq("R5 R8 R9", $sformatf("outbound path %0d", k), 32'(padOutV[k]), 32'(expOut(k)));
    end
  end

  task automatic stepEdges(input int n, input bit slow);
    for (int s = 0; s < n; s++) begin
      @(clk);
      #1;
      if (!slow || (s % 6) == 0) begin
        padIn   = 6'($urandom);
        coreOut = 5'($urandom);
      end
    end
  endtask

  task automatic writeCfg(input logic [31:0] word);
    @(posedge clk);
    #1;
    checkOn   = 0;
    cfgWrEn   = 1'b1;
    cfgWrData = word;
    @(posedge clk);
    #1;
    cfgWrEn   = 1'b0;
    cfgShadow = word & 32'h01FF_FFFF;
    #2;
    // R2: readback of stored bits, reserved bits zero
    checkEq("R2", "control readback", cfgRdData, word & 32'h01FF_FFFF);
    stepEdges(16, 1'b0);  // R9: settle window after a rewrite
    checkOn = 1;
  endtask

  function automatic logic [31:0] buildCfg(input int c, input int o);
    logic [31:0] w = 32'hA600_0000;  // reserved bits set on purpose
    for (int j = 0; j < 6; j++) w[inLsb(j) +: 2] = 2'((c + j) % 4);
    for (int k = 0; k < 5; k++) w[10 + 2 * k +: 2] = 2'((c + 2 + k) % 4);
    w[20] = o[0];
    w[21] = o[1];
    w[24] = c[0] ^ o[0];
    return w;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    padIn = 6'h3F;
    coreOut = '0;
    #(CLK_PERIOD * 3 + 2);
    // R1: reset state
    checkEq("R1", "sync outputs in reset", 32'(syncV), 32'd0);
    checkEq("R1", "readback in reset", cfgRdData, 32'd0);
    checkEq("R1", "outbound pads in reset", 32'(padOutV), 32'd0);
    padIn = '0;
    #(CLK_PERIOD);
    rstN = 1'b1;
    recOn = 1;
    // default timing straight after reset (R1, R3)
    cfgShadow = '0;
    stepEdges(12, 1'b0);
    checkOn = 1;
    stepEdges(60, 1'b0);
    checkOn = 0;
    for (int c = 0; c < 4; c++) begin
      for (int o = 0; o < 4; o++) begin
        writeCfg(buildCfg(c, o));
        stepEdges(60, 1'b0);
        stepEdges(60, 1'b1);
      end
    end
    // return to all-zero word: no stuck path after a large code change (R9)
    writeCfg(32'h0);
    stepEdges(40, 1'b0);
    checkOn = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule